// File: doc/BRIEF.md
# Input Channel Alarm Latching and Data Conditioning

This block sits behind the per-channel framing and defect detectors of a multi-channel byte-stream receiver. For every input channel it receives three defect levels from upstream: loss of frame alignment, loss of signal, and a parity error. It also receives a provisioning bit. From these it keeps a registered alarm status word and a sticky change bit for each alarm. The sticky bits can be read and cleared by software. Through a per-alarm mask, they drive one shared interrupt line.

On the data side, each channel's byte stream passes through with one register of latency. When the channel is unprovisioned, out of frame, or has lost signal, the stream is overwritten with a filler pattern. A per-channel select picks the pattern: all-ones for an alarm indication, or all-zeros for an idle, unequipped payload. The decision to substitute is taken only on the frame-start strobe, so a frame is either passed whole or replaced whole. While a channel is substituted, the parity-error flag that travels downstream with its data is forced low. Detecting the defects themselves is done elsewhere.

Top module: `alm_input_cond`

## Requirements
- R1: For a provisioned channel, the reported loss-of-frame and loss-of-signal alarm bits equal the corresponding defect inputs, one clock after those inputs are sampled. Alarm bit index for channel c is 3c+0 for loss of frame, 3c+1 for loss of signal, and 3c+2 for parity.
- R2: The reported parity alarm of a channel is held low in any cycle after a sample where that channel shows loss of frame or loss of signal. Otherwise it follows the parity-error input, one clock later.
- R3: An unprovisioned channel (provisioning bit 0) reports all three alarms low, one clock later. It therefore cannot set sticky bits or raise the interrupt through its own alarms.
- R4: A sticky bit is set in the same cycle its reported alarm bit changes, on both a 0-to-1 change and a 1-to-0 change.
- R5: A write strobe with a clear word clears each sticky bit whose clear-word bit is 1. Bits written as 0 are unaffected. A change in the same cycle wins over the clear.
- R6: The interrupt output is high exactly when some sticky bit and its mask bit are both 1. It responds to the mask without a clock delay.
- R7: The substitution state of a channel changes only in a cycle with the frame-start strobe. On that strobe it becomes (not provisioned) or loss-of-frame or loss-of-signal, and it applies from the byte presented with the strobe onward.
- R8: While substituting, the output byte is all-ones if the pattern select was 1 at the last frame-start strobe, and all-zeros if it was 0.
- R9: While not substituting, the output byte equals the input byte presented one clock earlier.
- R10: The downstream parity-error flag is the parity-error input registered one clock, forced to 0 for bytes that are substituted.
- R11: During reset the block shows every channel substituting, output bytes of zero, and the downstream flags, alarms, sticky bits and interrupt all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | High with the first byte of every frame |
| ch_data_i | input | NUM_CH*DATA_W | Input bytes, channel c in bits [c*DATA_W +: DATA_W] |
| prov_i | input | NUM_CH | Per-channel provisioning bit |
| oof_i | input | NUM_CH | Per-channel loss-of-frame defect level |
| los_i | input | NUM_CH | Per-channel loss-of-signal defect level |
| perr_i | input | NUM_CH | Per-channel parity-error level |
| ais_sel_i | input | NUM_CH | Filler select: 1 all-ones, 0 all-zeros |
| irq_mask_i | input | 3*NUM_CH | Per-alarm interrupt enable |
| clr_we_i | input | 1 | Sticky clear write strobe |
| clr_data_i | input | 3*NUM_CH | Write-one-to-clear word for the sticky bits |
| ch_data_o | output | NUM_CH*DATA_W | Conditioned output bytes |
| subst_o | output | NUM_CH | Channel currently substituted |
| ds_err_o | output | NUM_CH | Parity-error flag travelling downstream with the data |
| alarm_o | output | 3*NUM_CH | Registered alarm status |
| sticky_o | output | 3*NUM_CH | Sticky change bits |
| irq_o | output | 1 | Shared interrupt |

## Verification
Several rules are checked by the assertions on every cycle:
- the substitution state stays still between frame strobes;
- a substituted byte is always a solid filler;
- the downstream flag is silent under substitution;
- the parity alarm is masked by the other defects;
- an unprovisioned channel stays quiet;
- any alarm change leaves its sticky bit set;
- an uncleared sticky bit persists;
- the interrupt matches the masked sticky bits.

Other behaviour can only be shown by the bench's scenarios. This covers the pattern choice captured at the strobe, the one-cycle pass-through of real data, and which filler appears. It also covers the exact cycle an alarm appears and the result of a clear that collides with a change.

// File: rtl/alm_cond_pkg.sv
package alm_cond_pkg;

  localparam int ALM_PER_CH = 3;

  // Bit order inside a channel's alarm group; software decodes these positions.
  typedef struct packed {
    logic par;
    logic los;
    logic oof;
  } alm_vec_t;

endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/alm_chan_cond.sv
module alm_chan_cond #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prov_i,
  input  logic              oof_i,
  input  logic              los_i,
  input  logic              perr_i,
  input  logic              ais_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              subst_o,
  output logic              ds_err_o
);

  localparam logic [DATA_W-1:0] FILL_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] FILL_ZEROS = {DATA_W{1'b0}};

  logic              defect;
  logic              subst_q, subst_d, subst_en;
  logic              mode_q, mode_d;
  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              ds_q, ds_d;

  // Next-state: substitution and filler choice move only on the frame strobe.
  always_comb begin
    defect   = ~prov_i | oof_i | los_i;
    subst_en = frame_start_i;
    subst_d  = subst_en ? defect    : subst_q;
    mode_d   = subst_en ? ais_sel_i : mode_q;
    fill     = mode_d ? FILL_ONES : FILL_ZEROS;
    dat_d    = subst_d ? fill : data_i;
    ds_d     = perr_i & ~subst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subst_q <= 1'b1;
      mode_q  <= 1'b0;
    end else if (subst_en) begin
      subst_q <= subst_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= FILL_ZEROS;
      ds_q  <= 1'b0;
    end else begin
      dat_q <= dat_d;
      ds_q  <= ds_d;
    end
  end

  assign data_o   = dat_q;
  assign subst_o  = subst_q;
  assign ds_err_o = ds_q;

endmodule

// File: rtl/alm_chan_latch.sv
module alm_chan_latch
  import alm_cond_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prov_i,
  input  logic                  oof_i,
  input  logic                  los_i,
  input  logic                  perr_i,
  input  logic [ALM_PER_CH-1:0] clr_i,
  output logic [ALM_PER_CH-1:0] alarm_o,
  output logic [ALM_PER_CH-1:0] sticky_o
);

  alm_vec_t              raw;
  alm_vec_t              alm_q;
  logic [ALM_PER_CH-1:0] chg;
  logic [ALM_PER_CH-1:0] stk_q, stk_d;

  always_comb begin
    raw.oof = prov_i & oof_i;
    raw.los = prov_i & los_i;
    raw.par = prov_i & perr_i & ~oof_i & ~los_i;
    chg     = raw ^ alm_q;
    stk_d   = (stk_q & ~clr_i) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
      stk_q <= '0;
    end else begin
      alm_q <= raw;
      stk_q <= stk_d;
    end
  end

  assign alarm_o  = alm_q;
  assign sticky_o = stk_q;

endmodule

// File: rtl/alm_irq_merge.sv
module alm_irq_merge #(
  parameter int N = 12
) (
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);

  assign irq_o = |(sticky_i & mask_i);

endmodule

// File: rtl/alm_input_cond.sv
module alm_input_cond
  import alm_cond_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start_i,
  input  logic [NUM_CH*DATA_W-1:0] ch_data_i,
  input  logic [NUM_CH-1:0]        prov_i,
  input  logic [NUM_CH-1:0]        oof_i,
  input  logic [NUM_CH-1:0]        los_i,
  input  logic [NUM_CH-1:0]        perr_i,
  input  logic [NUM_CH-1:0]        ais_sel_i,
  input  logic [3*NUM_CH-1:0]      irq_mask_i,
  input  logic                     clr_we_i,
  input  logic [3*NUM_CH-1:0]      clr_data_i,
  output logic [NUM_CH*DATA_W-1:0] ch_data_o,
  output logic [NUM_CH-1:0]        subst_o,
  output logic [NUM_CH-1:0]        ds_err_o,
  output logic [3*NUM_CH-1:0]      alarm_o,
  output logic [3*NUM_CH-1:0]      sticky_o,
  output logic                     irq_o
);

  localparam int ALM_W = ALM_PER_CH * NUM_CH;

  logic             rst_int_n;
  logic [ALM_W-1:0] clr_word;

  alm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign clr_word = clr_we_i ? clr_data_i : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    alm_chan_cond #(.DATA_W(DATA_W)) u_cond (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .frame_start_i (frame_start_i),
      .data_i        (ch_data_i[c*DATA_W +: DATA_W]),
      .prov_i        (prov_i[c]),
      .oof_i         (oof_i[c]),
      .los_i         (los_i[c]),
      .perr_i        (perr_i[c]),
      .ais_sel_i     (ais_sel_i[c]),
      .data_o        (ch_data_o[c*DATA_W +: DATA_W]),
      .subst_o       (subst_o[c]),
      .ds_err_o      (ds_err_o[c])
    );

    alm_chan_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .prov_i   (prov_i[c]),
      .oof_i    (oof_i[c]),
      .los_i    (los_i[c]),
      .perr_i   (perr_i[c]),
      .clr_i    (clr_word[c*ALM_PER_CH +: ALM_PER_CH]),
      .alarm_o  (alarm_o[c*ALM_PER_CH +: ALM_PER_CH]),
      .sticky_o (sticky_o[c*ALM_PER_CH +: ALM_PER_CH])
    );
  end

  alm_irq_merge #(.N(ALM_W)) u_irq (
    .sticky_i (sticky_o),
    .mask_i   (irq_mask_i),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/alm_input_cond_chk.sv
module alm_input_cond_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_start_i,
  input logic [NUM_CH-1:0]        prov_i,
  input logic [NUM_CH-1:0]        oof_i,
  input logic [NUM_CH-1:0]        los_i,
  input logic [3*NUM_CH-1:0]      irq_mask_i,
  input logic                     clr_we_i,
  input logic [3*NUM_CH-1:0]      clr_data_i,
  input logic [NUM_CH*DATA_W-1:0] ch_data_o,
  input logic [NUM_CH-1:0]        subst_o,
  input logic [NUM_CH-1:0]        ds_err_o,
  input logic [3*NUM_CH-1:0]      alarm_o,
  input logic [3*NUM_CH-1:0]      sticky_o,
  input logic                     irq_o
);

  localparam int ALM_W = 3 * NUM_CH;

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(sticky_o & irq_mask_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_unprov_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !prov_i[c] |=> alarm_o[3*c +: 3] == 3'b000);

    p_par_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (oof_i[c] || los_i[c]) |=> !alarm_o[3*c+2]);

    p_subst_frame_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start_i |=> $stable(subst_o[c]));

    p_fill_solid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      subst_o[c] |-> (ch_data_o[c*DATA_W +: DATA_W] == {DATA_W{1'b1}} ||
                      ch_data_o[c*DATA_W +: DATA_W] == {DATA_W{1'b0}}));

    p_ds_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      subst_o[c] |-> !ds_err_o[c]);
  end

  for (genvar i = 0; i < ALM_W; i++) begin : g_a
    p_change_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alarm_o[i]) |-> sticky_o[i]);

    p_sticky_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_o[i] && !(clr_we_i && clr_data_i[i])) |=> sticky_o[i]);
  end

endmodule

bind alm_input_cond alm_input_cond_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .prov_i        (prov_i),
  .oof_i         (oof_i),
  .los_i         (los_i),
  .irq_mask_i    (irq_mask_i),
  .clr_we_i      (clr_we_i),
  .clr_data_i    (clr_data_i),
  .ch_data_o     (ch_data_o),
  .subst_o       (subst_o),
  .ds_err_o      (ds_err_o),
  .alarm_o       (alarm_o),
  .sticky_o      (sticky_o),
  .irq_o         (irq_o)
);

// File: tb/alm_input_cond_tb.sv
module alm_input_cond_tb_top;

  localparam int NC = 4;
  localparam int DW = 8;
  localparam int AW = 3 * NC;

  logic             clk;
  logic             rst_n;
  logic             frame_start_i;
  logic [NC*DW-1:0] ch_data_i;
  logic [NC-1:0]    prov_i, oof_i, los_i, perr_i, ais_sel_i;
  logic [AW-1:0]    irq_mask_i;
  logic             clr_we_i;
  logic [AW-1:0]    clr_data_i;
  logic [NC*DW-1:0] ch_data_o;
  logic [NC-1:0]    subst_o, ds_err_o;
  logic [AW-1:0]    alarm_o, sticky_o;
  logic             irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // Bench model state
  logic [NC-1:0]    m_subst, m_mode, m_ds;
  logic [NC*DW-1:0] m_data;
  logic [AW-1:0]    m_alm, m_stk;

  alm_input_cond #(.NUM_CH(NC), .DATA_W(DW)) dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] raw_alarms();
    logic [AW-1:0] r;
    for (int c = 0; c < NC; c++) begin
      r[3*c]   = prov_i[c] & oof_i[c];
      r[3*c+1] = prov_i[c] & los_i[c];
      r[3*c+2] = prov_i[c] & perr_i[c] & ~oof_i[c] & ~los_i[c];
    end
    return r;
  endfunction

  task automatic compare_all();
    logic irq_exp;
    irq_exp = |(m_stk & irq_mask_i);
    chk(ch_data_o == m_data, "R8 R9 data", 64'(ch_data_o), 64'(m_data));
    chk(subst_o == m_subst, "R7 subst", 64'(subst_o), 64'(m_subst));
    chk(alarm_o == m_alm, "R1 R2 R3 alarm", 64'(alarm_o), 64'(m_alm));
    chk(sticky_o == m_stk, "R4 R5 sticky", 64'(sticky_o), 64'(m_stk));
    chk(irq_o == irq_exp, "R6 irq", 64'(irq_o), 64'(irq_exp));
    chk(ds_err_o == m_ds, "R10 ds_err", 64'(ds_err_o), 64'(m_ds));
  endtask

  // Inputs are set at a negedge; one clock edge is taken and outputs compared at the next negedge.
  task automatic step();
    logic [AW-1:0] raw, clr;
    raw = raw_alarms();
    clr = clr_we_i ? clr_data_i : '0;
    for (int c = 0; c < NC; c++) begin
      if (frame_start_i) begin
        m_subst[c] = ~prov_i[c] | oof_i[c] | los_i[c];
        m_mode[c]  = ais_sel_i[c];
      end
      m_data[c*DW +: DW] = m_subst[c] ? (m_mode[c] ? {DW{1'b1}} : {DW{1'b0}})
                                      : ch_data_i[c*DW +: DW];
      m_ds[c] = perr_i[c] & ~m_subst[c];
    end
    m_stk = (m_stk & ~clr) | (raw ^ m_alm);
    m_alm = raw;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    frame_start_i = 0; ch_data_i = '0; prov_i = '0; oof_i = '0; los_i = '0;
    perr_i = '0; ais_sel_i = '0; irq_mask_i = '0; clr_we_i = 0; clr_data_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    m_subst = '1; m_mode = '0; m_ds = '0; m_data = '0; m_alm = '0; m_stk = '0;
    compare_all();
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all();

    // R9 R7: provision all, take a frame strobe, data passes through
    prov_i = '1; irq_mask_i = '1; ch_data_i = 32'hA1B2C3D4; step();
    frame_start_i = 1; ch_data_i = 32'h11223344; step();
    frame_start_i = 0; ch_data_i = 32'h55667788; step();

    // R1 R4 R6 R7: loss of frame on ch1 mid-frame; no substitution yet
    oof_i[1] = 1; step(); step();

    // R8: strobe with all-ones filler on ch1
    ais_sel_i[1] = 1; frame_start_i = 1; step();
    frame_start_i = 0; step();

    // R8: all-zeros filler on ch2 after loss of signal
    ais_sel_i[2] = 0; los_i[2] = 1; step();
    frame_start_i = 1; step();
    frame_start_i = 0;

    // R5 R4: clear all while ch1 alarm falls; change wins over clear
    oof_i[1] = 0; clr_we_i = 1; clr_data_i = '1; step();
    clr_we_i = 0; step();
    // R5: clear word of zeros has no effect
    clr_we_i = 1; clr_data_i = '0; step();
    clr_we_i = 0;

    // R2 R10: parity error under loss of signal is masked; downstream flag silent
    perr_i[2] = 1; step(); step();
    // R10: parity on a passing channel travels downstream
    perr_i[0] = 1; step();
    perr_i = '0;

    // R3: unprovisioned channel with defects stays silent
    prov_i[3] = 0; los_i[3] = 1; perr_i[3] = 1; step(); step();
    frame_start_i = 1; step();
    frame_start_i = 0; step();

    // Random phase: all requirements checked each cycle against the model
    for (int n = 0; n < 3000; n++) begin
      ch_data_i     = {$urandom, $urandom};
      frame_start_i = ($urandom % 8) == 0;
      for (int c = 0; c < NC; c++) begin
        if ($urandom % 10 == 0) oof_i[c]  = ~oof_i[c];
        if ($urandom % 10 == 0) los_i[c]  = ~los_i[c];
        if ($urandom % 6  == 0) perr_i[c] = ~perr_i[c];
        if ($urandom % 40 == 0) prov_i[c] = ~prov_i[c];
        if ($urandom % 20 == 0) ais_sel_i[c] = ~ais_sel_i[c];
      end
      if ($urandom % 25 == 0) irq_mask_i = AW'($urandom);
      clr_we_i   = ($urandom % 6) == 0;
      clr_data_i = AW'($urandom);
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule